// File: doc/BRIEF.md
# Reset Qualifier and Boot Latch

This block turns a raw, active-high reset pin into a clean internal reset for a small controller. The pin is first brought into the oscillator clock domain through a two-flop synchronizer. The internal reset is raised only after the synchronized pin has stayed high without a break for a full qualification window. That window is two machine cycles, and a machine cycle is twelve oscillator periods. If the pin drops before the window is complete, the count starts again from zero. When the pin goes low, the internal reset falls as soon as the synchronizer shows the low level.

While the internal reset is active, the block keeps copying the program-source select pin into a boot register. Once reset ends, that register is frozen: the pin has no further effect until the next qualified reset. Before the first qualified reset, the register reads as internal memory.

The block also contains a guard for code-table reads. A read request carries a flag that tells whether the requesting instruction runs from external program space. When the security strap is set, any such request that targets the internal code region is refused. The grant is registered and is never given while the internal reset is active.

Top module: `boot_reset_ctrl`

## Requirements
- R1: With the pin held high on HOLD = 24 consecutive rising clock edges (the first of them counted as edge 1), `rst_o` goes high on edge HOLD+2 and is low on edge HOLD+1.
- R2: A pin pulse that is high on only HOLD-1 consecutive edges never raises `rst_o`.
- R3: A single low sample on the pin clears the qualification count. Two HOLD-1 edge high runs split by one low edge do not raise `rst_o`.
- R4: After the pin goes low, `rst_o` is still high on the second rising edge and low on the third.
- R5: From power-up until the first qualified reset, `mem_sel_o` reads 0 (internal program memory) and `rst_o` reads 0, whatever `ext_sel_i` does.
- R6: While `rst_o` is high, `mem_sel_o` follows `ext_sel_i` (1 = external program memory, 0 = internal) through a two-flop synchronizer.
- R7: While `rst_o` is low, a change on `ext_sel_i` leaves `mem_sel_o` unchanged.
- R8: `rd_grant_o` is registered. It reflects the request of the previous edge, is 0 when no request was made, and is 0 for any request sampled while `rst_o` is high.
- R9: When `secure_i`=1, `rd_from_ext_i`=1, `mem_sel_o`=0 and `rd_addr_i` < INT_BYTES (4096), the request is refused (`rd_grant_o`=0). This includes address 0x0FFF.
- R10: A request is granted when any one of these holds: `secure_i`=0, `rd_from_ext_i`=0, `rd_addr_i` >= INT_BYTES, or `mem_sel_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_pin_i | input | 1 | Raw active-high reset pin, asynchronous |
| ext_sel_i | input | 1 | Program source select pin, 1 = external |
| secure_i | input | 1 | Security strap, 1 = protect internal code |
| rd_req_i | input | 1 | Code-table read request |
| rd_from_ext_i | input | 1 | Requester executes from external program space |
| rd_addr_i | input | ADDR_W (16) | Code address of the read |
| rst_o | output | 1 | Qualified internal reset, active high |
| mem_sel_o | output | 1 | Latched program source, 1 = external |
| rd_grant_o | output | 1 | Registered read grant |

## Verification
Each check is tied to a known latency. A rising pin edge shows on `rst_o` at edge HOLD+2, and a falling pin edge shows at the third edge. A change on the select pin reaches `mem_sel_o` three edges later, and only while reset is active. A read request shows on `rd_grant_o` at the next edge. The driver changes inputs on falling edges and files each expected value with the exact clock count at which it is due. The monitor compares only on falling edges whose count matches, and a hold-off is checked with samples taken well after the latency has passed.

// File: rtl/bootrst_pkg.sv
package bootrst_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } prog_src_e;

endpackage

// File: rtl/bootrst_sync.sv
module bootrst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q = '0;
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) chain_q <= d_i[b];
    end else begin : g_multi
      always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/bootrst_qualifier.sv
module bootrst_qualifier #(
  parameter int OSC_PER_MC = 12,
  parameter int MC_HOLD    = 2
) (
  input  logic clk_i,
  input  logic pin_s_i,
  output logic rst_o
);

  localparam int HOLD = OSC_PER_MC * MC_HOLD;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIM    = CW'(HOLD);
  localparam logic [CW-1:0] LIM_M1 = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q = '0;
  logic          rst_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (!pin_s_i)          cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    rst_q <= pin_s_i && (cnt_q >= LIM_M1);
  end

  assign rst_o = rst_q;

  AST_RISE_AT_FULL_COUNT: assert property (@(posedge clk_i)
    $rose(rst_q) |-> (cnt_q == LIM)); // R1
  AST_COUNT_BOUNDED: assert property (@(posedge clk_i)
    cnt_q <= LIM); // R2
  AST_LOW_CLEARS_COUNT: assert property (@(posedge clk_i)
    !pin_s_i |=> (cnt_q == '0)); // R3
  AST_LOW_DROPS_RESET: assert property (@(posedge clk_i)
    !pin_s_i |=> !rst_q); // R4

endmodule

// File: rtl/bootrst_boot_latch.sv
module bootrst_boot_latch
  import bootrst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic sel_s_i,
  output logic mem_sel_o
);

  prog_src_e src_q = SRC_INTERNAL;

  always_ff @(posedge clk_i) begin
    if (rst_i) src_q <= prog_src_e'(sel_s_i);
  end

  assign mem_sel_o = (src_q == SRC_EXTERNAL);

  AST_SEL_CAPTURED: assert property (@(posedge clk_i)
    rst_i |=> (mem_sel_o == $past(sel_s_i))); // R6
  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> $stable(mem_sel_o)); // R7

endmodule

// File: rtl/bootrst_code_gate.sv
module bootrst_code_gate #(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              mem_sel_i,
  input  logic              secure_i,
  input  logic              req_i,
  input  logic              from_ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              grant_o
);

  localparam logic [ADDR_W:0] INT_LIM = (ADDR_W+1)'(INT_BYTES);

  logic int_target;
  logic blocked;
  logic grant_q = 1'b0;

  assign int_target = !mem_sel_i && ({1'b0, addr_i} < INT_LIM);
  assign blocked    = secure_i && from_ext_i && int_target;

  always_ff @(posedge clk_i) begin
    if (rst_i) grant_q <= 1'b0;
    else       grant_q <= req_i && !blocked;
  end

  assign grant_o = grant_q;

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_q |-> $past(req_i)); // R8
  AST_PROTECTED_DENIED: assert property (@(posedge clk_i) disable iff (rst_i)
    (secure_i && from_ext_i && !mem_sel_i && ({1'b0, addr_i} < INT_LIM)) |=> !grant_q); // R9

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl #(
  parameter int OSC_PER_MC = 12,
  parameter int MC_HOLD    = 2,
  parameter int SYNC_STG   = 2,
  parameter int ADDR_W     = 16,
  parameter int INT_BYTES  = 4096
) (
  input  logic              clk_i,
  input  logic              rst_pin_i,
  input  logic              ext_sel_i,
  input  logic              secure_i,
  input  logic              rd_req_i,
  input  logic              rd_from_ext_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rst_o,
  output logic              mem_sel_o,
  output logic              rd_grant_o
);

  logic [1:0] pins_s;
  logic       rst_int;
  logic       sel_int;

  bootrst_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .d_i   ({ext_sel_i, rst_pin_i}),
    .q_o   (pins_s)
  );

  bootrst_qualifier #(.OSC_PER_MC(OSC_PER_MC), .MC_HOLD(MC_HOLD)) u_qual (
    .clk_i   (clk_i),
    .pin_s_i (pins_s[0]),
    .rst_o   (rst_int)
  );

  bootrst_boot_latch u_latch (
    .clk_i     (clk_i),
    .rst_i     (rst_int),
    .sel_s_i   (pins_s[1]),
    .mem_sel_o (sel_int)
  );

  bootrst_code_gate #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_gate (
    .clk_i      (clk_i),
    .rst_i      (rst_int),
    .mem_sel_i  (sel_int),
    .secure_i   (secure_i),
    .req_i      (rd_req_i),
    .from_ext_i (rd_from_ext_i),
    .addr_i     (rd_addr_i),
    .grant_o    (rd_grant_o)
  );

  assign rst_o     = rst_int;
  assign mem_sel_o = sel_int;

endmodule

// File: tb/test_boot_reset_ctrl.sv
module test_boot_reset_ctrl;

  localparam int HOLD = 24;

  logic        clk = 1'b0;
  logic        rst_pin = 1'b0, ext_sel = 1'b0, secure = 1'b0;
  logic        req = 1'b0, from_ext = 1'b0;
  logic [15:0] addr = '0;
  logic        rst_o, mem_sel_o, rd_grant_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    kind;
    logic  val;
    string tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  boot_reset_ctrl i_boot_reset_ctrl (
    .clk_i(clk), .rst_pin_i(rst_pin), .ext_sel_i(ext_sel), .secure_i(secure),
    .rd_req_i(req), .rd_from_ext_i(from_ext), .rd_addr_i(addr),
    .rst_o(rst_o), .mem_sel_o(mem_sel_o), .rd_grant_o(rd_grant_o)
  );

  function automatic logic pick(int kind);
    case (kind)
      0:       return rst_o;
      1:       return mem_sel_o;
      default: return rd_grant_o;
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      0:       return "rst_o";
      1:       return "mem_sel_o";
      default: return "rd_grant_o";
    endcase
  endfunction

  task automatic check_now(int kind, logic v, string tag);
    checks++;
    if (pick(kind) !== v) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (cycle %0d)", tag, kname(kind), pick(kind), v, cyc);
    end
  endtask

  task automatic want(int d, int kind, logic v, string tag);
    sb.push_back('{cyc + d, kind, v, tag});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops due items on falling edges
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check_now(sb[i].kind, sb[i].val, sb[i].tag);
        sb.delete(i);
      end
    end
  end

  task automatic read_case(logic s, logic fe, logic [15:0] a, logic exp, string tag);
    secure = s; from_ext = fe; addr = a; req = 1'b1;
    want(1, 2, exp, tag);
    step(1);
  endtask

  initial begin
    #1;
    check_now(0, 1'b0, "R5");
    check_now(1, 1'b0, "R5");
    step(1);
    want(3, 0, 1'b0, "R5");
    want(3, 2, 1'b0, "R8");
    step(5);

    ext_sel = 1'b1;
    step(4);
    // R2: pulse one edge short
    rst_pin = 1'b1;
    want(HOLD + 2, 0, 1'b0, "R2");
    want(HOLD + 3, 0, 1'b0, "R2");
    step(HOLD - 1);
    rst_pin = 1'b0;
    step(8);

    // R3: two short runs split by one low edge
    rst_pin = 1'b1;
    want(HOLD + 2, 0, 1'b0, "R3");
    want(2 * HOLD + 2, 0, 1'b0, "R3");
    step(HOLD - 1);
    rst_pin = 1'b0;
    step(1);
    rst_pin = 1'b1;
    step(HOLD - 1);
    rst_pin = 1'b0;
    want(6, 1, 1'b0, "R5");
    step(8);

    // R1: qualified reset, select external captured
    rst_pin = 1'b1;
    want(HOLD + 1, 0, 1'b0, "R1");
    want(HOLD + 2, 0, 1'b1, "R1");
    step(HOLD + 2);
    req = 1'b1;
    want(1, 2, 1'b0, "R8");
    want(1, 1, 1'b1, "R6");
    step(3);
    req = 1'b0;
    rst_pin = 1'b0;
    want(2, 0, 1'b1, "R4");
    want(3, 0, 1'b0, "R4");
    step(4);

    // R7: pin change after reset ignored
    ext_sel = 1'b0;
    want(5, 1, 1'b1, "R7");
    want(10, 1, 1'b1, "R7");
    step(10);

    read_case(1'b1, 1'b1, 16'h0010, 1'b1, "R10");
    req = 1'b0;
    want(1, 2, 1'b0, "R8");
    step(2);

    // second reset, select internal captured
    rst_pin = 1'b1;
    step(HOLD + 4);
    want(1, 1, 1'b0, "R6");
    step(1);
    rst_pin = 1'b0;
    step(4);

    read_case(1'b1, 1'b1, 16'h0100, 1'b0, "R9");
    read_case(1'b1, 1'b1, 16'h1000, 1'b1, "R10");
    read_case(1'b1, 1'b1, 16'h0FFF, 1'b0, "R9");
    read_case(1'b1, 1'b0, 16'h0100, 1'b1, "R10");
    read_case(1'b0, 1'b1, 16'h0100, 1'b1, "R10");
    req = 1'b0;
    step(3);

    ext_sel = 1'b1;
    want(6, 1, 1'b0, "R7");
    step(10);

    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule